// File: doc/BRIEF.md
# Three-Context Program Counter Sequencer with Instruction Quantum

This block holds three independent program counters, one each for interrupt handling, supervisor code and a user task, and picks which of them feeds instruction fetch. Supervisor software starts a user task with a switch command that carries a 16-bit instruction budget. The sequencer clears the user counter, runs the user context for exactly that many retired instructions and then hands control back to the supervisor by itself.

An interrupt request taken in supervisor or user context moves control to the interrupt counter. That counter is loaded with a vectored entry address: base `0x100` plus the vector times 16. While the handler runs, the user budget is frozen. The handler's return command picks the context that resumes: user or supervisor. A request that arrives while the handler is already running is held and taken once the handler returns.

The controller is a three-state machine. Its states are `ST_SUP` (supervisor, mode code 0), `ST_USR` (user, mode code 1) and `ST_IRQ` (handler, mode code 2). Its transitions are:
- dispatch: `ST_SUP` to `ST_USR`
- empty dispatch: `ST_SUP` to `ST_SUP`
- expiry: `ST_USR` to `ST_SUP`
- take: `ST_SUP` or `ST_USR` to `ST_IRQ`
- resume-user: `ST_IRQ` to `ST_USR`
- resume-supervisor: `ST_IRQ` to `ST_SUP`

Top module: `pc_mode_ctrl`

## Requirements
- R1: After reset, the mode is 0 (supervisor), all three counters are 0, the active PC is 0 and no interrupt is held.
- R2: The mode output encodes supervisor as 0, user as 1 and handler as 2. The active PC is the supervisor counter in mode 0, the user counter in mode 1 and the handler counter in mode 2.
- R3: On a retire strobe, only the counter of the current mode advances, by 4. The other two counters hold their values.
- R4: In supervisor mode, a switch command with a nonzero budget n clears the user counter, loads the budget and enters user mode on the next cycle.
- R5: A switch command with budget 0 clears the user counter but stays in supervisor mode, so no user instruction runs.
- R6: In user mode, the retire that consumes the last unit of budget returns the next cycle to supervisor mode. The supervisor counter is then unchanged from when it left.
- R7: An interrupt request in supervisor or user mode enters handler mode on the next cycle, with the handler counter at 0x100 + vector*16. This takes priority over a same-cycle switch command and over a same-cycle budget expiry. A retire in that same cycle still counts for the context being left.
- R8: The remaining budget and the user counter are frozen in handler mode. Returning to the user resumes at the same user PC with the same remaining budget.
- R9: A return command in handler mode with resume-user 0 enters supervisor mode. With resume-user 1, it enters user mode if budget remains, and supervisor mode otherwise.
- R10: An interrupt request in handler mode is held without leaving handler mode, and later requests are dropped while one is held. The held request is taken the cycle after control leaves handler mode, using the first held vector.
- R11: A switch command has no effect outside supervisor mode, and a return command has no effect outside handler mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired in the current context |
| irq_i | input | 1 | Interrupt request strobe |
| irq_vec_i | input | 3 | Interrupt vector number |
| switch_i | input | 1 | Dispatch the user task (supervisor only) |
| quantum_i | input | 16 | Instruction budget for the dispatch |
| ret_i | input | 1 | Return from handler |
| ret_user_i | input | 1 | Return target: 1 user, 0 supervisor |
| active_pc_o | output | 32 | PC driving instruction fetch |
| mode_o | output | 2 | Current mode code |

## Verification
The hardest situations to reach are those where events coincide with budget boundaries and handler nesting. Examples are an interrupt arriving on the very retire that exhausts the budget, and a request held inside the handler that must fire one cycle after the return. The bench sweeps every budget from 0 to 6 and every vector. It then drives these coincidences deliberately: retire plus interrupt on the last budget unit, and two requests during a handler before a return. A cycle-level model built from the requirements predicts the mode and the active PC after every edge.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    typedef enum logic [1:0] {
        ST_SUP = 2'd0,
        ST_USR = 2'd1,
        ST_IRQ = 2'd2
    } pcm_state_e;

    // Counter slots inside the bank
    localparam int SLOT_IRQ = 0;
    localparam int SLOT_SUP = 1;
    localparam int SLOT_USR = 2;
    localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/pcm_pc_bank.sv
module pcm_pc_bank #(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4,
    parameter int SLOTS   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        retire_i,
    input  logic [SLOTS-1:0]            active_oh,
    input  logic [SLOTS-1:0]            load_en,
    input  logic [SLOTS-1:0][PC_W-1:0]  load_val,
    output logic [SLOTS-1:0][PC_W-1:0]  pc_q
);
    localparam logic [PC_W-1:0] STEP_L = PC_W'(PC_STEP);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [PC_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (load_en[g])
                cnt_q <= load_val[g];
            else if (retire_i && active_oh[g])
                cnt_q <= cnt_q + STEP_L;
        end
        assign pc_q[g] = cnt_q;
    end
endmodule

// File: rtl/pcm_quantum.sv
module pcm_quantum #(
    parameter int Q_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [Q_W-1:0] load_val_i,
    input  logic           dec_i,
    output logic [Q_W-1:0] count_o,
    output logic           last_o,
    output logic           zero_o
);
    logic [Q_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == Q_W'(1));
    assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/pcm_irq_hold.sv
module pcm_irq_hold #(
    parameter int VEC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             clear_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] pend_vec_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o     <= 1'b0;
            pend_vec_o <= '0;
        end else if (clear_i) begin
            pend_o     <= 1'b0;
        end else if (capture_i && !pend_o) begin
            pend_o     <= 1'b1;
            pend_vec_o <= vec_i;
        end
    end
endmodule

// File: rtl/pc_mode_ctrl.sv
module pc_mode_ctrl
    import pcm_pkg::*;
#(
    parameter int          PC_W      = 32,
    parameter int          Q_W       = 16,
    parameter int          VEC_W     = 3,
    parameter int          PC_STEP   = 4,
    parameter logic [31:0] VEC_BASE  = 32'h100,
    parameter int          VEC_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             irq_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic             switch_i,
    input  logic [Q_W-1:0]   quantum_i,
    input  logic             ret_i,
    input  logic             ret_user_i,
    output logic [PC_W-1:0]  active_pc_o,
    output logic [1:0]       mode_o
);
    localparam logic [PC_W-1:0] BASE_L = PC_W'(VEC_BASE);

    pcm_state_e state_q, state_d;

    logic                             pend_q;
    logic [VEC_W-1:0]                 pend_vec;
    logic [VEC_W-1:0]                 take_vec;
    logic                             take;
    logic [Q_W-1:0]                   q_cnt;
    logic                             q_last, q_zero;
    logic                             q_load, q_dec;
    logic [NUM_SLOTS-1:0]             active_oh;
    logic [NUM_SLOTS-1:0]             load_en;
    logic [NUM_SLOTS-1:0][PC_W-1:0]   load_val;
    logic [NUM_SLOTS-1:0][PC_W-1:0]   pcs;

    // Interrupt acceptance: any context except the handler itself
    assign take     = (state_q != ST_IRQ) && (irq_i || pend_q);
    assign take_vec = pend_q ? pend_vec : irq_vec_i;

    assign q_load = (state_q == ST_SUP) && switch_i && !take;
    assign q_dec  = (state_q == ST_USR) && retire_i;

    always_comb begin
        load_en  = '0;
        load_val = '0;
        load_en[SLOT_USR]  = q_load;
        load_en[SLOT_IRQ]  = take;
        load_val[SLOT_IRQ] = BASE_L + (PC_W'(take_vec) << VEC_SHIFT);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUP: begin
                if (take)
                    state_d = ST_IRQ;
                else if (switch_i && quantum_i != '0)
                    state_d = ST_USR;
            end
            ST_USR: begin
                if (take)
                    state_d = ST_IRQ;
                else if (retire_i && q_last)
                    state_d = ST_SUP;
            end
            ST_IRQ: begin
                if (ret_i)
                    state_d = (ret_user_i && !q_zero) ? ST_USR : ST_SUP;
            end
            default: state_d = ST_SUP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SUP;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        active_oh   = '0;
        active_pc_o = '0;
        unique case (state_q)
            ST_SUP: begin
                active_oh[SLOT_SUP] = 1'b1;
                active_pc_o         = pcs[SLOT_SUP];
            end
            ST_USR: begin
                active_oh[SLOT_USR] = 1'b1;
                active_pc_o         = pcs[SLOT_USR];
            end
            ST_IRQ: begin
                active_oh[SLOT_IRQ] = 1'b1;
                active_pc_o         = pcs[SLOT_IRQ];
            end
            default: begin
                active_oh   = '0;
                active_pc_o = '0;
            end
        endcase
        mode_o = state_q;
    end

    pcm_pc_bank #(
        .PC_W    (PC_W),
        .PC_STEP (PC_STEP),
        .SLOTS   (NUM_SLOTS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .active_oh (active_oh),
        .load_en   (load_en),
        .load_val  (load_val),
        .pc_q      (pcs)
    );

    pcm_quantum #(
        .Q_W (Q_W)
    ) u_quantum (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (q_load),
        .load_val_i (quantum_i),
        .dec_i      (q_dec),
        .count_o    (q_cnt),
        .last_o     (q_last),
        .zero_o     (q_zero)
    );

    pcm_irq_hold #(
        .VEC_W (VEC_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  ((state_q == ST_IRQ) && irq_i),
        .clear_i    (take),
        .vec_i      (irq_vec_i),
        .pend_o     (pend_q),
        .pend_vec_o (pend_vec)
    );
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
    parameter int          PC_W      = 32,
    parameter int          Q_W       = 16,
    parameter int          VEC_W     = 3,
    parameter logic [31:0] VEC_BASE  = 32'h100,
    parameter int          VEC_SHIFT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 retire_i,
    input logic                 irq_i,
    input logic [VEC_W-1:0]     irq_vec_i,
    input logic                 switch_i,
    input logic [Q_W-1:0]       quantum_i,
    input logic                 ret_i,
    input logic                 ret_user_i,
    input logic [PC_W-1:0]      active_pc_o,
    input logic [1:0]           mode_o,
    input logic [Q_W-1:0]       q_cnt,
    input logic                 pend_q,
    input logic [2:0][PC_W-1:0] pcs
);
    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    assert_sup_pc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |=> $stable(pcs[1]));

    assert_empty_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && switch_i && quantum_i == '0 && !irq_i && !pend_q)
        |=> mode_o == 2'd0);

    assert_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && retire_i && q_cnt == Q_W'(1) && !irq_i && !pend_q)
        |=> mode_o == 2'd0);

    assert_take_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd2 && irq_i && !pend_q)
        |=> (mode_o == 2'd2 &&
             active_pc_o == PC_W'(VEC_BASE) + (PC_W'($past(irq_vec_i)) << VEC_SHIFT)));

    assert_frozen_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> $stable(q_cnt));

    assert_return_sup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && ret_i && !ret_user_i) |=> mode_o == 2'd0);

    assert_nested_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && irq_i && !ret_i) |=> (mode_o == 2'd2 && pend_q));

    assert_switch_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && switch_i && !retire_i && !irq_i && !pend_q)
        |=> (mode_o == 2'd1 && $stable(active_pc_o)));
endmodule

bind pc_mode_ctrl pcm_checker #(
    .PC_W      (PC_W),
    .Q_W       (Q_W),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_SHIFT (VEC_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .irq_i       (irq_i),
    .irq_vec_i   (irq_vec_i),
    .switch_i    (switch_i),
    .quantum_i   (quantum_i),
    .ret_i       (ret_i),
    .ret_user_i  (ret_user_i),
    .active_pc_o (active_pc_o),
    .mode_o      (mode_o),
    .q_cnt       (q_cnt),
    .pend_q      (pend_q),
    .pcs         (pcs)
);

// File: tb/pc_mode_ctrl_bench.sv
module pc_mode_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0, irq_i = 1'b0, switch_i = 1'b0;
    logic        ret_i = 1'b0, ret_user_i = 1'b0;
    logic [2:0]  irq_vec_i = '0;
    logic [15:0] quantum_i = '0;
    logic [31:0] active_pc_o;
    logic [1:0]  mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected state, built from the requirements
    int unsigned e_p1 = 0, e_p2 = 0, e_p3 = 0, e_q = 0, e_m = 0, e_pv = 0;
    bit          e_pend = 0;

    always #4 clk = ~clk;

    pc_mode_ctrl u_pc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .irq_i(irq_i),
        .irq_vec_i(irq_vec_i), .switch_i(switch_i), .quantum_i(quantum_i),
        .ret_i(ret_i), .ret_user_i(ret_user_i),
        .active_pc_o(active_pc_o), .mode_o(mode_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int unsigned exp_pc();
        return (e_m == 0) ? e_p2 : (e_m == 1) ? e_p3 : e_p1;
    endfunction

    // Drive one cycle at a falling edge, update model, check at next falling edge
    task automatic cyc(input string tag, input bit rt, input bit sw, input int n,
                       input bit rq, input bit ru, input bit iq, input int v);
        bit take;
        int unsigned tv, nm;
        retire_i = rt; switch_i = sw; quantum_i = 16'(n);
        ret_i = rq; ret_user_i = ru; irq_i = iq; irq_vec_i = 3'(v);
        take = (e_m != 2) && (iq || e_pend);
        tv   = e_pend ? e_pv : v;
        nm   = e_m;
        if (rt) begin
            if (e_m == 0) e_p2 += 4;
            else if (e_m == 1) begin e_p3 += 4; if (e_q != 0) e_q--; end
            else e_p1 += 4;
        end
        if (e_m == 0 && sw && !take) begin
            e_p3 = 0; e_q = n; nm = (n != 0) ? 1 : 0;
        end
        if (e_m == 1 && rt && e_q == 0) nm = 0;
        if (e_m == 2 && rq) nm = (ru && e_q != 0) ? 1 : 0;
        if (e_m == 2 && iq && !e_pend) begin e_pend = 1; e_pv = v; end
        if (take) begin e_p1 = 32'h100 + tv * 16; nm = 2; e_pend = 0; end
        e_m = nm;
        @(negedge clk);
        retire_i = 0; switch_i = 0; ret_i = 0; ret_user_i = 0; irq_i = 0;
        check({tag, " mode"}, {30'd0, mode_o}, e_m);
        check({tag, " pc"}, active_pc_o, exp_pc());
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 mode", {30'd0, mode_o}, 0);
        check("R1 pc", active_pc_o, 0);
        idle("R1");

        // R3 supervisor retires advance PC2 only
        for (int i = 0; i < 4; i++) cyc("R3", 1, 0, 0, 0, 0, 0, 0);

        // R4 R5 R6 budget sweep
        for (int n = 0; n <= 6; n++) begin
            cyc(n == 0 ? "R5" : "R4", 0, 1, n, 0, 0, 0, 0);
            for (int k = 0; k < n; k++) begin
                cyc("R6", 1, 0, 0, 0, 0, 0, 0);
                if (k % 2 == 0 && k + 1 < n) idle("R2");
            end
            cyc("R6", 1, 0, 0, 0, 0, 0, 0);
        end

        // R7 R9 vector sweep from supervisor
        for (int v = 0; v < 8; v++) begin
            cyc("R7", 0, 0, 0, 0, 0, 1, v);
            check("R7 entry", active_pc_o, 32'h100 + v * 16);
            cyc("R3", 1, 0, 0, 0, 0, 0, 0);
            cyc("R3", 1, 0, 0, 0, 0, 0, 0);
            cyc("R9", 0, 0, 0, 1, 0, 0, 0);
        end

        // R8 mid-budget interrupt then resume user
        cyc("R4", 0, 1, 5, 0, 0, 0, 0);
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 1, 3);
        for (int k = 0; k < 3; k++) cyc("R8", 1, 0, 0, 0, 0, 0, 0);
        cyc("R11 ret", 0, 1, 2, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 1, 0, 0);
        check("R8 resume", active_pc_o, 8);
        cyc("R11 sw", 0, 1, 9, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc("R6", 1, 0, 0, 0, 0, 0, 0);
        check("R6 back", {30'd0, mode_o}, 0);
        cyc("R11 ret", 0, 0, 0, 1, 1, 0, 0);

        // R7 R9 interrupt on the expiring retire, resume-user finds none left
        cyc("R4", 0, 1, 1, 0, 0, 0, 0);
        cyc("R7", 1, 0, 0, 0, 0, 1, 6);
        cyc("R9", 0, 0, 0, 1, 1, 0, 0);
        check("R9 empty", {30'd0, mode_o}, 0);

        // R10 nested requests held, first vector kept
        cyc("R7", 0, 0, 0, 0, 0, 1, 1);
        cyc("R10", 0, 0, 0, 0, 0, 1, 5);
        cyc("R10", 1, 0, 0, 0, 0, 1, 6);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0);
        idle("R10");
        check("R10 held entry", active_pc_o, 32'h150);
        cyc("R9", 0, 0, 0, 1, 0, 0, 0);

        // R7 interrupt beats a same-cycle switch
        cyc("R7", 0, 1, 4, 0, 0, 1, 7);
        cyc("R9", 0, 0, 0, 1, 1, 0, 0);
        check("R7 no dispatch", {30'd0, mode_o}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule